// File: doc/BRIEF.md
# Flash Operation Status Flag Generator

This block forms the byte a flash device places on its data pins when the host reads while an embedded program or erase is active, failed or suspended. It combines the current operation kind, the run state, the polled bit 7 of the byte being programmed, the sector of the read address and two sector masks into a status byte. The status byte has a polling bit (7), an activity toggle (6), a limit flag (5), an erase-window flag (3) and a sector-local erase toggle (2). When no operation touches the read, array data passes through unchanged.

The two toggle bits are registers. They advance on a read strobe, which the surrounding logic derives from the falling edge of the chip or output enable and presents as a one-cycle pulse. A read always returns the toggle value held before that strobe's edge, so two back-to-back reads of a toggling bit differ. The block is purely a status path: the command decoder, timers and array sit around it.

The block works in one of six modes, each decoded from the inputs in every cycle:
- PASS: no operation or a finished one.
- PROG: byte program busy.
- CHIP: chip erase busy.
- SECT: sector erase busy, including the acceptance window.
- FAIL: limit exceeded.
- SUSP: sector erase suspended.

The only state is the pair of toggle registers. Each one either holds or inverts on a strobe, as the mode in force at that edge selects.

Top module: `flash_status_gen`

## Requirements
- R1: `op_kind` encodes 0 = none, 1 = byte program, 2 = chip erase, 3 = sector erase. In status bytes, bit 7 reads the inverse of `prog_bit7` for a program and reads 0 for either erase.
- R2: `run_state` encodes 0 = busy, 1 = suspended, 2 = limit exceeded, 3 = done. With `op_kind` = 0 or `run_state` = 3, `dout` equals `array_data`.
- R3: Bit 6 inverts after every read strobe at any address while an operation is busy or failed, including while the erase window is open. In pass-through mode a strobe leaves both toggles unchanged.
- R4: Bit 5 reads 1 in the limit-exceeded state and 0 in every other status byte. Bits 7, 6 and 2 keep their behaviour while it is set.
- R5: For a busy sector erase, bit 3 reads 0 while `win_open` is 1 and reads 1 once it is 0. Chip erase and failed erases read bit 3 as 1.
- R6: For a busy sector erase, bit 2 inverts on a strobe only when `erase_mask` has the read sector's bit set. For a busy chip erase it inverts at every address. A `rd_sector` value of NSECT or more lies in no sector.
- R7: In the limit-exceeded state, bit 2 inverts on a strobe only when `fail_mask` has the read sector's bit set.
- R8: For a suspended sector erase, a read of a sector in `erase_mask` returns bit 7 = 1, bit 5 = 0 and bit 3 = 0, with bit 6 held and bit 2 inverting per strobe. A read of any other sector returns `array_data`.
- R9: For a program, bit 3 reads 0. Bit 2 holds unless the read sector is set in `erase_mask` (a program nested in an erase suspend), in which case it inverts per strobe.
- R10: Reset clears both toggle registers to 0. Bits 4, 1 and 0 of every status byte read 0.
- R11: A suspended state given with a program or chip erase is treated as busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the toggle registers |
| op_kind | input | 2 | Operation kind (R1 encoding) |
| run_state | input | 2 | Run state (R2 encoding) |
| prog_bit7 | input | 1 | Bit 7 of the byte being programmed |
| rd_sector | input | SEC_W | Sector index of the read address |
| erase_mask | input | NSECT | Sectors selected for erase |
| fail_mask | input | NSECT | Sectors in which the limit was exceeded |
| win_open | input | 1 | Sector erase acceptance window open |
| rd_strobe | input | 1 | One-cycle read strobe |
| array_data | input | 8 | Byte read from the array |
| dout | output | 8 | Status byte or array data |

## Verification
A wrong mode decode shows at once: the same cycle's `dout` carries the wrong polling, limit or window bit, or array data where status belongs. A toggle register that advances in the wrong mode or sector shows on the next read of that bit, one strobe later. Either a repeated value appears where an inversion was due, or a change appears in a bit that should be steady. The bench therefore compares the full byte on every cycle against a model that carries its own two toggle bits.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;

    typedef enum logic [1:0] {
        OPK_NONE = 2'd0,
        OPK_PROG = 2'd1,
        OPK_CHIP = 2'd2,
        OPK_SECT = 2'd3
    } opk_e;

    typedef enum logic [1:0] {
        RUN_BUSY = 2'd0,
        RUN_SUSP = 2'd1,
        RUN_FAIL = 2'd2,
        RUN_DONE = 2'd3
    } run_e;

    typedef enum logic [2:0] {
        MD_PASS,
        MD_PROG,
        MD_CHIP,
        MD_SECT,
        MD_FAIL,
        MD_SUSP
    } mode_e;

    localparam int BIT_POLL  = 7;
    localparam int BIT_TGL   = 6;
    localparam int BIT_LIMIT = 5;
    localparam int BIT_WIN   = 3;
    localparam int BIT_ETGL  = 2;

endpackage

// File: rtl/flash_mode_decode.sv
module flash_mode_decode
    import flash_status_pkg::*;
(
    input  opk_e  kind,
    input  run_e  run,
    output mode_e mode
);

    always_comb begin
        mode = MD_PASS;
        unique case (run)
            RUN_DONE: mode = MD_PASS;
            RUN_FAIL: mode = (kind == OPK_NONE) ? MD_PASS : MD_FAIL;
            RUN_BUSY, RUN_SUSP: begin
                unique case (kind)
                    OPK_NONE: mode = MD_PASS;
                    OPK_PROG: mode = MD_PROG;
                    OPK_CHIP: mode = MD_CHIP;
                    OPK_SECT: mode = (run == RUN_SUSP) ? MD_SUSP : MD_SECT;
                endcase
            end
        endcase
    end

endmodule

// File: rtl/flash_sector_hit.sv
module flash_sector_hit #(
    parameter int NSECT = 7,
    parameter int SEC_W = (NSECT > 1) ? $clog2(NSECT) : 1
) (
    input  logic [SEC_W-1:0] sector,
    input  logic [NSECT-1:0] erase_mask,
    input  logic [NSECT-1:0] fail_mask,
    output logic             erase_hit,
    output logic             fail_hit
);

    logic [NSECT-1:0] sel;

    generate
        for (genvar i = 0; i < NSECT; i++) begin : g_sel
            assign sel[i] = (sector == SEC_W'(i));
        end
    endgenerate

    assign erase_hit = |(sel & erase_mask);
    assign fail_hit  = |(sel & fail_mask);

endmodule

// File: rtl/flash_toggle_bit.sv
module flash_toggle_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic flip,
    output logic q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (flip) begin
            q <= ~q;
        end
    end

endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
    import flash_status_pkg::*;
#(
    parameter int NSECT = 7,
    localparam int SEC_W = (NSECT > 1) ? $clog2(NSECT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       op_kind,
    input  logic [1:0]       run_state,
    input  logic             prog_bit7,
    input  logic [SEC_W-1:0] rd_sector,
    input  logic [NSECT-1:0] erase_mask,
    input  logic [NSECT-1:0] fail_mask,
    input  logic             win_open,
    input  logic             rd_strobe,
    input  logic [7:0]       array_data,
    output logic [7:0]       dout
);

    mode_e mode;
    opk_e  kind;
    logic  erase_hit;
    logic  fail_hit;
    logic  tog6_q;
    logic  tog2_q;
    logic  tog6_adv;
    logic  tog2_adv;

    assign kind = opk_e'(op_kind);

    flash_mode_decode u_mode (
        .kind (kind),
        .run  (run_e'(run_state)),
        .mode (mode)
    );

    flash_sector_hit #(.NSECT(NSECT), .SEC_W(SEC_W)) u_hit (
        .sector     (rd_sector),
        .erase_mask (erase_mask),
        .fail_mask  (fail_mask),
        .erase_hit  (erase_hit),
        .fail_hit   (fail_hit)
    );

    // Advance conditions for the two toggle registers, per mode.
    always_comb begin
        tog6_adv = 1'b0;
        tog2_adv = 1'b0;
        unique case (mode)
            MD_PASS: begin
                tog6_adv = 1'b0;
                tog2_adv = 1'b0;
            end
            MD_PROG: begin
                tog6_adv = rd_strobe;
                tog2_adv = rd_strobe & erase_hit;
            end
            MD_CHIP: begin
                tog6_adv = rd_strobe;
                tog2_adv = rd_strobe;
            end
            MD_SECT: begin
                tog6_adv = rd_strobe;
                tog2_adv = rd_strobe & erase_hit;
            end
            MD_FAIL: begin
                tog6_adv = rd_strobe;
                tog2_adv = rd_strobe & fail_hit;
            end
            MD_SUSP: begin
                tog6_adv = 1'b0;
                tog2_adv = rd_strobe & erase_hit;
            end
        endcase
    end

    flash_toggle_bit u_tog6 (
        .clk   (clk),
        .rst_n (rst_n),
        .flip  (tog6_adv),
        .q     (tog6_q)
    );

    flash_toggle_bit u_tog2 (
        .clk   (clk),
        .rst_n (rst_n),
        .flip  (tog2_adv),
        .q     (tog2_q)
    );

    // Output byte, per mode.
    always_comb begin
        dout = 8'h00;
        unique case (mode)
            MD_PASS: dout = array_data;
            MD_PROG: begin
                dout[BIT_POLL]  = ~prog_bit7;
                dout[BIT_TGL]   = tog6_q;
                dout[BIT_ETGL]  = tog2_q;
            end
            MD_CHIP: begin
                dout[BIT_TGL]   = tog6_q;
                dout[BIT_WIN]   = 1'b1;
                dout[BIT_ETGL]  = tog2_q;
            end
            MD_SECT: begin
                dout[BIT_TGL]   = tog6_q;
                dout[BIT_WIN]   = ~win_open;
                dout[BIT_ETGL]  = tog2_q;
            end
            MD_FAIL: begin
                dout[BIT_POLL]  = (kind == OPK_PROG) ? ~prog_bit7 : 1'b0;
                dout[BIT_TGL]   = tog6_q;
                dout[BIT_LIMIT] = 1'b1;
                dout[BIT_WIN]   = (kind != OPK_PROG);
                dout[BIT_ETGL]  = tog2_q;
            end
            MD_SUSP: begin
                if (erase_hit) begin
                    dout[BIT_POLL] = 1'b1;
                    dout[BIT_TGL]  = tog6_q;
                    dout[BIT_ETGL] = tog2_q;
                end else begin
                    dout = array_data;
                end
            end
        endcase
    end

endmodule

// File: rtl/flash_status_chk.sv
module flash_status_chk #(
    parameter int NSECT = 7,
    localparam int SEC_W = (NSECT > 1) ? $clog2(NSECT) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       op_kind,
    input logic [1:0]       run_state,
    input logic             prog_bit7,
    input logic             rd_strobe,
    input logic [7:0]       array_data,
    input logic [7:0]       dout,
    input logic             erase_hit,
    input logic             tog6_q,
    input logic             tog2_q
);

    logic active_run;
    logic suspended;
    assign active_run = (op_kind != 2'd0) && (run_state != 2'd3);
    assign suspended  = (op_kind == 2'd3) && (run_state == 2'd1);

    AST_POLL_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        (op_kind == 2'd1 && run_state != 2'd3) |-> (dout[7] != prog_bit7)); // R1

    AST_PASS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (op_kind == 2'd0 || run_state == 2'd3) |-> (dout == array_data)); // R2

    AST_TGL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && active_run && !suspended) |=> (tog6_q != $past(tog6_q))); // R3

    AST_TGL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !active_run) |=> ($stable(tog6_q) && $stable(tog2_q))); // R3

    AST_LIMIT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (op_kind != 2'd0 && run_state == 2'd2) |-> dout[5]); // R4

    AST_SUSP_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (suspended && erase_hit) |-> (dout[7] && !dout[5] && !dout[3])); // R8

    AST_SUSP_HOLD6: assert property (@(posedge clk) disable iff (!rst_n)
        (suspended && rd_strobe) |=> $stable(tog6_q)); // R8

    AST_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (active_run && !(suspended && !erase_hit)) |-> (dout[4] == 1'b0 && dout[1:0] == 2'b00)); // R10

endmodule

bind flash_status_gen flash_status_chk #(.NSECT(NSECT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_kind    (op_kind),
    .run_state  (run_state),
    .prog_bit7  (prog_bit7),
    .rd_strobe  (rd_strobe),
    .array_data (array_data),
    .dout       (dout),
    .erase_hit  (erase_hit),
    .tog6_q     (tog6_q),
    .tog2_q     (tog2_q)
);

// File: tb/sim_flash_status_gen.sv
module sim_flash_status_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] op_kind = 2'd0;
    logic [1:0] run_state = 2'd0;
    logic       prog_bit7 = 1'b0;
    logic [2:0] rd_sector = 3'd0;
    logic [6:0] erase_mask = 7'd0;
    logic [6:0] fail_mask = 7'd0;
    logic       win_open = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [7:0] array_data = 8'h00;
    logic [7:0] dout;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    bit m6 = 1'b0;
    bit m2 = 1'b0;

    always #5 clk = ~clk;

    flash_status_gen #(.NSECT(7)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_kind    (op_kind),
        .run_state  (run_state),
        .prog_bit7  (prog_bit7),
        .rd_sector  (rd_sector),
        .erase_mask (erase_mask),
        .fail_mask  (fail_mask),
        .win_open   (win_open),
        .rd_strobe  (rd_strobe),
        .array_data (array_data),
        .dout       (dout)
    );

    function automatic bit in_mask(input logic [2:0] s, input logic [6:0] m);
        return (s < 3'd7) && m[s];
    endfunction

    function automatic logic [7:0] exp_byte(input logic [1:0] k, input logic [1:0] r,
                                            input logic b7, input logic [2:0] s,
                                            input logic [6:0] em, input logic w,
                                            input logic [7:0] arr, input bit t6, input bit t2);
        logic [7:0] e;
        e = 8'h00;
        if (k == 2'd0 || r == 2'd3) return arr;
        if (k == 2'd3 && r == 2'd1) begin
            if (!in_mask(s, em)) return arr;
            e[7] = 1'b1; e[6] = t6; e[2] = t2;
            return e;
        end
        e[7] = (k == 2'd1) ? ~b7 : 1'b0;
        e[6] = t6;
        e[5] = (r == 2'd2);
        if (k == 2'd1)      e[3] = 1'b0;
        else if (k == 2'd2) e[3] = 1'b1;
        else                e[3] = (r == 2'd2) ? 1'b1 : ~w;
        e[2] = t2;
        return e;
    endfunction

    function automatic string tag_of(input logic [1:0] k, input logic [1:0] r);
        if (k == 2'd0 || r == 2'd3) return "R2";
        if (k == 2'd3 && r == 2'd1) return "R8";
        if (r == 2'd2) return "R4";
        if (k == 2'd1) return "R9";
        if (k == 2'd2) return "R6";
        return "R5";
    endfunction

    task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s dout=%02h expected=%02h (op=%0d run=%0d sec=%0d)",
                     tag, got, exp, op_kind, run_state, rd_sector);
        end
    endtask

    task automatic step(input logic [1:0] k, input logic [1:0] r, input logic b7,
                        input logic [2:0] s, input logic [6:0] em, input logic [6:0] fm,
                        input logic w, input logic st, input logic [7:0] arr, input string tag);
        bit susp;
        bit act;
        bit n6;
        bit n2;
        @(negedge clk);
        op_kind = k; run_state = r; prog_bit7 = b7; rd_sector = s;
        erase_mask = em; fail_mask = fm; win_open = w; rd_strobe = st; array_data = arr;
        #1;
        check(dout, exp_byte(k, r, b7, s, em, w, arr, m6, m2), tag);
        act  = (k != 2'd0) && (r != 2'd3);
        susp = (k == 2'd3) && (r == 2'd1);
        n6 = m6; n2 = m2;
        if (st && act) begin
            if (!susp) n6 = ~m6;
            if (susp)             n2 = m2 ^ in_mask(s, em);
            else if (r == 2'd2)   n2 = m2 ^ in_mask(s, fm);
            else if (k == 2'd2)   n2 = ~m2;
            else                  n2 = m2 ^ in_mask(s, em);
        end
        @(posedge clk);
        m6 = n6; m2 = n2;
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10: toggles start at 0 after reset, low bits read 0
        step(2'd1, 2'd0, 1'b0, 3'd0, 7'h00, 7'h00, 1'b0, 1'b0, 8'h5A, "R10");
        // R1: program polls inverse of bit 7
        step(2'd1, 2'd0, 1'b1, 3'd0, 7'h00, 7'h00, 1'b0, 1'b1, 8'h5A, "R1");
        // R3: bit 6 inverted after strobe; R9: bit 2 held
        step(2'd1, 2'd0, 1'b1, 3'd2, 7'h00, 7'h00, 1'b0, 1'b1, 8'h5A, "R3");
        step(2'd1, 2'd0, 1'b1, 3'd2, 7'h00, 7'h00, 1'b0, 1'b0, 8'h5A, "R9");
        // R9: program nested in suspend, read of suspended sector toggles bit 2
        step(2'd1, 2'd0, 1'b0, 3'd4, 7'h10, 7'h00, 1'b0, 1'b1, 8'h00, "R9");
        step(2'd1, 2'd0, 1'b0, 3'd4, 7'h10, 7'h00, 1'b0, 1'b0, 8'h00, "R9");
        // R5: sector erase window open then closed, bit 6 toggles in window
        step(2'd3, 2'd0, 1'b0, 3'd1, 7'h02, 7'h00, 1'b1, 1'b1, 8'hFF, "R5");
        step(2'd3, 2'd0, 1'b0, 3'd1, 7'h02, 7'h00, 1'b1, 1'b0, 8'hFF, "R5");
        step(2'd3, 2'd0, 1'b0, 3'd1, 7'h02, 7'h00, 1'b0, 1'b0, 8'hFF, "R5");
        // R6: non-selected sector does not toggle bit 2
        step(2'd3, 2'd0, 1'b0, 3'd5, 7'h02, 7'h00, 1'b0, 1'b1, 8'hFF, "R6");
        step(2'd3, 2'd0, 1'b0, 3'd5, 7'h02, 7'h00, 1'b0, 1'b0, 8'hFF, "R6");
        // R6: chip erase toggles bit 2 even at an out-of-range sector
        step(2'd2, 2'd0, 1'b0, 3'd7, 7'h00, 7'h00, 1'b0, 1'b1, 8'hFF, "R6");
        step(2'd2, 2'd0, 1'b0, 3'd7, 7'h00, 7'h00, 1'b0, 1'b0, 8'hFF, "R6");
        // R11: chip erase with suspended state behaves as busy
        step(2'd2, 2'd1, 1'b0, 3'd0, 7'h00, 7'h00, 1'b0, 1'b1, 8'h11, "R11");
        step(2'd2, 2'd1, 1'b0, 3'd0, 7'h00, 7'h00, 1'b0, 1'b0, 8'h11, "R11");
        // R4/R7: failed erase, bit 2 only in failed sector
        step(2'd3, 2'd2, 1'b0, 3'd3, 7'h0C, 7'h08, 1'b0, 1'b1, 8'h00, "R7");
        step(2'd3, 2'd2, 1'b0, 3'd2, 7'h0C, 7'h08, 1'b0, 1'b1, 8'h00, "R7");
        step(2'd3, 2'd2, 1'b0, 3'd2, 7'h0C, 7'h08, 1'b0, 1'b0, 8'h00, "R4");
        // R8: suspended erase, hit and miss
        step(2'd3, 2'd1, 1'b0, 3'd6, 7'h40, 7'h00, 1'b0, 1'b1, 8'hA5, "R8");
        step(2'd3, 2'd1, 1'b0, 3'd6, 7'h40, 7'h00, 1'b0, 1'b0, 8'hA5, "R8");
        step(2'd3, 2'd1, 1'b0, 3'd0, 7'h40, 7'h00, 1'b0, 1'b1, 8'hA5, "R8");
        // R2/R3: done state passes data, strobes freeze toggles
        step(2'd3, 2'd3, 1'b0, 3'd6, 7'h40, 7'h00, 1'b0, 1'b1, 8'h3C, "R2");
        step(2'd0, 2'd0, 1'b0, 3'd6, 7'h40, 7'h00, 1'b0, 1'b1, 8'hC3, "R2");
        step(2'd3, 2'd0, 1'b0, 3'd6, 7'h40, 7'h00, 1'b0, 1'b0, 8'h00, "R3");

        // Constrained random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [1:0] k;
            logic [1:0] r;
            logic [2:0] s;
            logic [6:0] em;
            logic [6:0] fm;
            k  = 2'($urandom_range(0, 3));
            r  = ($urandom_range(0, 9) < 5) ? 2'd0 : 2'($urandom_range(1, 3));
            s  = 3'($urandom_range(0, 7));
            em = 7'($urandom);
            fm = 7'($urandom) & em;
            step(k, r, 1'($urandom), s, em, fm, 1'($urandom),
                 ($urandom_range(0, 3) != 0), 8'($urandom), tag_of(k, r));
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule